// File: doc/BRIEF.md
# Cross-Clock Mailbox Register

This block carries a single word from a port clocked by `clkA` to a port clocked by `clkB`, outside the normal FIFO path. Port A loads the word by selecting the mailbox path during a write. An active-low pending flag in port A's clock domain then shows that the word has not yet been taken. While the flag is low, further mailbox writes are refused, so the held word cannot change under the reader.

Port B takes the word by selecting the mailbox path during a read. That read returns the flag to its idle state, after a hand-over back into port A's clock. Each direction of the hand-over is a toggle that passes through a two-stage synchronizer. The port B output bus is a multiplexer: it shows the FIFO output register when the mailbox select is low, and the mailbox word when the select is high. The word stays in the register after it has been read. The bus is tri-state in concept, so it is modelled here as an output-enable signal.

Top module: `xclk_mailbox`

## Requirements
- R1: While reset is asserted and after it is released, `mbxFullN` is 1 and the mailbox holds zero, so `bData` reads 0 when `bMbxSel` is 1.
- R2: A qualified write loads `aData` into the mailbox and drives `mbxFullN` to 0 after that `clkA` edge, provided `mbxFullN` was 1. A qualified write is a rising `clkA` edge with `aCsN`=0, `aWrRd`=1, `aMbxSel`=1 and `aEn`=1.
- R3: A `clkA` edge that has any one of the four write qualifiers at its inactive value changes neither the mailbox word nor `mbxFullN`.
- R4: While `mbxFullN` is 0, a qualified write is ignored: the mailbox word and the flag stay as they were.
- R5: A qualified read while a word is pending returns `mbxFullN` to 1. The flag is still 0 at the first falling `clkA` edge after the read, and it is 1 by the fifth falling `clkA` edge after the read. A qualified read is a rising `clkB` edge with `bCsN`=0, `bWrRd`=0, `bMbxSel`=1 and `bEn`=1.
- R6: A qualified read while no word is pending has no effect. A later write still holds `mbxFullN` at 0 until a read occurs after that write.
- R7: `bData` equals `fifoWord` when `bMbxSel` is 0, and equals the mailbox word when `bMbxSel` is 1.
- R8: After a read, the mailbox word stays valid. It can be read again with the same value, and `mbxFullN` stays 1.
- R9: `bOutEn` is 1 exactly when `bCsN` is 0 and `bWrRd` is 0.
- R10: A `clkB` edge that has any one of the four read qualifiers at its inactive value does not release a pending word: `mbxFullN` stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | Port A clock |
| clkB | input | 1 | Port B clock |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| aCsN | input | 1 | Port A chip select, active low |
| aWrRd | input | 1 | Port A direction, 1 = write |
| aMbxSel | input | 1 | Port A mailbox path select |
| aEn | input | 1 | Port A transfer enable |
| aData | input | 36 | Port A write data |
| mbxFullN | output | 1 | Mailbox pending flag in the `clkA` domain, 0 = word waiting |
| bCsN | input | 1 | Port B chip select, active low |
| bWrRd | input | 1 | Port B direction, 0 = read |
| bMbxSel | input | 1 | Port B mailbox select, also selects the output source |
| bEn | input | 1 | Port B transfer enable |
| fifoWord | input | 36 | FIFO output register contents |
| bData | output | 36 | Port B output bus |
| bOutEn | output | 1 | Port B bus drive enable |

## Verification
Suppose a toggle is lost or a spurious one is created. The pending flag then stays low for good or rises with no read, and this is visible within about four `clkA` cycles of the event. A mailbox register that overwrites while the flag is low shows the wrong word on `bData` at the next mailbox read, which the scoreboard compares with the word queued at write time. A mis-wired output select shows up at once, on the same cycle, as a `fifoWord` value where the mailbox word was expected, or the reverse.

// File: rtl/xclk_mailbox_pkg.sv
package xclk_mailbox_pkg;
  // strobes passed from control to datapath
  typedef struct packed {
    logic loadWord;   // clkA domain: capture port A data
    logic showMbx;    // output multiplexer select
  } mbxStrobes_t;
endpackage

// File: rtl/xclk_mailbox_sync.sv
module xclk_mailbox_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  localparam int unsigned LAST = STAGES - 1;
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= din;
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) chain <= '0;
        else       chain <= {chain[LAST-1:0], din};
    end
  endgenerate

  assign dout = chain[LAST];
endmodule

// File: rtl/xclk_mailbox_ctrl.sv
module xclk_mailbox_ctrl
  import xclk_mailbox_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic        clkA,
  input  logic        clkB,
  input  logic        rstN,
  input  logic        aCsN,
  input  logic        aWrRd,
  input  logic        aMbxSel,
  input  logic        aEn,
  input  logic        bCsN,
  input  logic        bWrRd,
  input  logic        bMbxSel,
  input  logic        bEn,
  output mbxStrobes_t strobes,
  output logic        fullN
);
  // ---------------- port A domain ----------------
  logic aReq, fullNReg, setTgl, clrSeen, clrSyncA, clrPulse;

  assign aReq     = !aCsN && aWrRd && aMbxSel && aEn;
  assign clrPulse = clrSyncA ^ clrSeen;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN) begin
      fullNReg <= 1'b1;
      setTgl   <= 1'b0;
      clrSeen  <= 1'b0;
    end else begin
      clrSeen <= clrSyncA;
      if (clrPulse) begin
        fullNReg <= 1'b1;
      end else if (aReq && fullNReg) begin
        fullNReg <= 1'b0;
        setTgl   <= ~setTgl;
      end
    end
  end

  // ---------------- port B domain ----------------
  logic bReq, clrTgl, setSyncB, bPending;

  assign bReq     = !bCsN && !bWrRd && bMbxSel && bEn;
  assign bPending = setSyncB ^ clrTgl;

  always_ff @(posedge clkB or negedge rstN) begin
    if (!rstN)                clrTgl <= 1'b0;
    else if (bReq && bPending) clrTgl <= ~clrTgl;
  end

  // ---------------- crossings ----------------
  xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) setSync_i (
    .clk(clkB), .rstN(rstN), .din(setTgl), .dout(setSyncB));

  xclk_mailbox_sync #(.STAGES(SYNC_STAGES)) clrSync_i (
    .clk(clkA), .rstN(rstN), .din(clrTgl), .dout(clrSyncA));

  assign strobes.loadWord = aReq && fullNReg;
  assign strobes.showMbx  = bMbxSel;
  assign fullN            = fullNReg;

  // ---------------- assertions ----------------
  assert_flag_falls_on_write_R2: assert property (
    @(posedge clkA) disable iff (!rstN) $fell(fullNReg) |-> $past(aReq));

  assert_no_set_while_full_R4: assert property (
    @(posedge clkA) disable iff (!rstN)
      (!fullNReg && $past(!fullNReg)) |-> $stable(setTgl));

  assert_clear_only_when_pending_R6: assert property (
    @(posedge clkB) disable iff (!rstN) !$stable(clrTgl) |-> $past(bPending));
endmodule

// File: rtl/xclk_mailbox_dp.sv
module xclk_mailbox_dp
  import xclk_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W = 36
) (
  input  logic              clkA,
  input  logic              rstN,
  input  mbxStrobes_t       strobes,
  input  logic              fullN,
  input  logic [DATA_W-1:0] aData,
  input  logic [DATA_W-1:0] fifoWord,
  output logic [DATA_W-1:0] bData
);
  logic [DATA_W-1:0] mbxWord;

  always_ff @(posedge clkA or negedge rstN) begin
    if (!rstN)                 mbxWord <= '0;
    else if (strobes.loadWord) mbxWord <= aData;
  end

  assign bData = strobes.showMbx ? mbxWord : fifoWord;

  assert_word_held_while_pending_R4: assert property (
    @(posedge clkA) disable iff (!rstN)
      (!fullN && $past(!fullN)) |-> $stable(mbxWord));
endmodule

// File: rtl/xclk_mailbox.sv
module xclk_mailbox
  import xclk_mailbox_pkg::*;
#(
  parameter int unsigned DATA_W      = 36,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rstN,
  input  logic              aCsN,
  input  logic              aWrRd,
  input  logic              aMbxSel,
  input  logic              aEn,
  input  logic [DATA_W-1:0] aData,
  output logic              mbxFullN,
  input  logic              bCsN,
  input  logic              bWrRd,
  input  logic              bMbxSel,
  input  logic              bEn,
  input  logic [DATA_W-1:0] fifoWord,
  output logic [DATA_W-1:0] bData,
  output logic              bOutEn
);
  mbxStrobes_t strobes;

  xclk_mailbox_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aCsN(aCsN), .aWrRd(aWrRd), .aMbxSel(aMbxSel), .aEn(aEn),
    .bCsN(bCsN), .bWrRd(bWrRd), .bMbxSel(bMbxSel), .bEn(bEn),
    .strobes(strobes), .fullN(mbxFullN));

  xclk_mailbox_dp #(.DATA_W(DATA_W)) dp_i (
    .clkA(clkA), .rstN(rstN), .strobes(strobes), .fullN(mbxFullN),
    .aData(aData), .fifoWord(fifoWord), .bData(bData));

  assign bOutEn = !bCsN && !bWrRd;
endmodule

// File: tb/xclk_mailbox_tb_top.sv
module xclk_mailbox_tb_top;
  localparam int W = 36;

  logic clkA = 1'b0, clkB = 1'b0, rstN = 1'b0;
  always #10 clkA = ~clkA;   // 50 MHz
  always #15 clkB = ~clkB;

  logic aCsN = 1'b1, aWrRd = 1'b0, aMbxSel = 1'b0, aEn = 1'b0;
  logic bCsN = 1'b1, bWrRd = 1'b1, bMbxSel = 1'b1, bEn = 1'b0;
  logic [W-1:0] aData = '0, fifoWord = '0;
  logic [W-1:0] bData;
  logic mbxFullN, bOutEn;

  xclk_mailbox dut_i (
    .clkA(clkA), .clkB(clkB), .rstN(rstN),
    .aCsN(aCsN), .aWrRd(aWrRd), .aMbxSel(aMbxSel), .aEn(aEn), .aData(aData),
    .mbxFullN(mbxFullN),
    .bCsN(bCsN), .bWrRd(bWrRd), .bMbxSel(bMbxSel), .bEn(bEn),
    .fifoWord(fifoWord), .bData(bData), .bOutEn(bOutEn));

  int errors = 0, checks = 0;
  logic [W-1:0] expQ[$];
  logic probe = 1'b0;
  string probeTag = "";

  task automatic check(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares the bus during each mailbox read
  always @(posedge probe) begin : monitor
    logic [W-1:0] e;
    #1;
    if (expQ.size() == 0) begin
      check(1'b0, {probeTag, " (empty queue)"}, 64'(bData), 64'h0);
    end else begin
      e = expQ.pop_front();
      check(bData === e && bOutEn === 1'b1, probeTag, 64'(bData), 64'(e));
    end
  end

  task automatic writeA(input logic [W-1:0] d, input logic cs, input logic wr,
                        input logic mb, input logic en);
    @(negedge clkA);
    aData = d; aCsN = cs; aWrRd = wr; aMbxSel = mb; aEn = en;
    @(negedge clkA);
    aCsN = 1'b1; aWrRd = 1'b0; aMbxSel = 1'b0; aEn = 1'b0;
  endtask

  task automatic readMbx(input logic [W-1:0] exp, input string tag);
    @(negedge clkB);
    bCsN = 1'b0; bWrRd = 1'b0; bMbxSel = 1'b1; bEn = 1'b1;
    expQ.push_back(exp);
    probeTag = tag;
    #2 probe = 1'b1;
    @(negedge clkB);
    probe = 1'b0;
    bCsN = 1'b1; bWrRd = 1'b1; bMbxSel = 1'b1; bEn = 1'b0;
  endtask

  task automatic driveB(input logic cs, input logic wr, input logic mb, input logic en);
    @(negedge clkB);
    bCsN = cs; bWrRd = wr; bMbxSel = mb; bEn = en;
    @(negedge clkB);
    bCsN = 1'b1; bWrRd = 1'b1; bMbxSel = 1'b1; bEn = 1'b0;
  endtask

  localparam logic [W-1:0] W1 = 36'h9_1234_ABCD;
  localparam logic [W-1:0] W2 = 36'h6_5555_0000;
  localparam logic [W-1:0] W3 = 36'hF_00FF_7E81;

  initial begin : watchdog
    repeat (100000) @(posedge clkA);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : driver
    fifoWord = 36'hA_5A5A_C3C3;
    repeat (3) @(negedge clkA);
    check(mbxFullN === 1'b1, "R1 flag during reset", 64'(mbxFullN), 64'h1);
    rstN = 1'b1;
    repeat (2) @(negedge clkA);
    check(mbxFullN === 1'b1, "R1 flag after reset", 64'(mbxFullN), 64'h1);
    check(bData === '0, "R1 mailbox zero", 64'(bData), 64'h0);
    check(bOutEn === 1'b0, "R9 idle enable", 64'(bOutEn), 64'h0);

    // R7: output source selection
    @(negedge clkB); bMbxSel = 1'b0; #1;
    check(bData === fifoWord, "R7 fifo path pattern 1", 64'(bData), 64'(fifoWord));
    fifoWord = 36'h1_0203_0405; #1;
    check(bData === fifoWord, "R7 fifo path pattern 2", 64'(bData), 64'(fifoWord));
    bMbxSel = 1'b1; #1;
    check(bData === '0, "R7 mailbox path", 64'(bData), 64'h0);

    // R9: output enable for each chip select / direction combination
    for (int k = 0; k < 4; k++) begin
      @(negedge clkB);
      bCsN = k[0]; bWrRd = k[1]; bEn = 1'b0; #1;
      check(bOutEn === (k == 0), "R9 output enable", 64'(bOutEn), 64'(k == 0));
    end
    bCsN = 1'b1; bWrRd = 1'b1;

    // R6: read with nothing pending, then a write must stay pending
    readMbx('0, "R6 empty read shows zero");
    repeat (4) @(negedge clkA);
    writeA(W1, 1'b0, 1'b1, 1'b1, 1'b1);
    check(mbxFullN === 1'b0, "R2 flag low after write", 64'(mbxFullN), 64'h0);
    check(bData === W1, "R2 word loaded", 64'(bData), 64'(W1));
    repeat (10) @(negedge clkA);
    check(mbxFullN === 1'b0, "R6 no spurious release", 64'(mbxFullN), 64'h0);

    // R4: write while pending is ignored
    writeA(W2, 1'b0, 1'b1, 1'b1, 1'b1);
    check(bData === W1, "R4 word kept", 64'(bData), 64'(W1));
    check(mbxFullN === 1'b0, "R4 flag kept", 64'(mbxFullN), 64'h0);

    // R10: incomplete reads do not release
    driveB(1'b0, 1'b0, 1'b1, 1'b0);
    driveB(1'b1, 1'b0, 1'b1, 1'b1);
    driveB(1'b0, 1'b0, 1'b0, 1'b1);
    driveB(1'b0, 1'b1, 1'b1, 1'b1);
    repeat (6) @(negedge clkA);
    check(mbxFullN === 1'b0, "R10 flag still low", 64'(mbxFullN), 64'h0);

    // R5: qualified read releases the flag after synchronization
    readMbx(W1, "R5 read returns word");
    check(mbxFullN === 1'b0, "R5 flag not yet released", 64'(mbxFullN), 64'h0);
    repeat (5) @(negedge clkA);
    check(mbxFullN === 1'b1, "R5 flag released", 64'(mbxFullN), 64'h1);

    // R8: word persists after read
    readMbx(W1, "R8 re-read same word");
    repeat (6) @(negedge clkA);
    check(mbxFullN === 1'b1, "R8 flag stays high", 64'(mbxFullN), 64'h1);

    // R3: each missing write qualifier
    writeA(W3, 1'b1, 1'b1, 1'b1, 1'b1);
    check(mbxFullN === 1'b1 && bData === W1, "R3 chip select high", 64'(bData), 64'(W1));
    writeA(W3, 1'b0, 1'b0, 1'b1, 1'b1);
    check(mbxFullN === 1'b1 && bData === W1, "R3 direction read", 64'(bData), 64'(W1));
    writeA(W3, 1'b0, 1'b1, 1'b0, 1'b1);
    check(mbxFullN === 1'b1 && bData === W1, "R3 mailbox not selected", 64'(bData), 64'(W1));
    writeA(W3, 1'b0, 1'b1, 1'b1, 1'b0);
    check(mbxFullN === 1'b1 && bData === W1, "R3 enable low", 64'(bData), 64'(W1));

    // R2/R5 repeated transfers with distinct words
    for (int n = 0; n < 3; n++) begin
      logic [W-1:0] w;
      w = W3 ^ (36'h1_1111_1111 * (n + 1));
      writeA(w, 1'b0, 1'b1, 1'b1, 1'b1);
      check(mbxFullN === 1'b0, "R2 flag low on transfer", 64'(mbxFullN), 64'h0);
      repeat (4) @(negedge clkB);
      readMbx(w, "R5 transfer word");
      repeat (5) @(negedge clkA);
      check(mbxFullN === 1'b1, "R5 flag released on transfer", 64'(mbxFullN), 64'h1);
    end

    repeat (4) @(negedge clkA);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule